// File: doc/BRIEF.md
# External Bus Idle-Cycle Scheduler

This block sits between an internal access-request port and the sequencer that drives an external memory bus. It takes one request at a time. Each request carries its memory kind (plain, SDRAM or PCMCIA), its direction, its size and its chip-select area. The block issues the request to the sequencer as one or more bus cycles. When the access is wider than the external data bus, it is cut into divided sub-cycles with incrementing byte addresses, and each one is tagged with its position in the sequence.

After the final cycle of an access, the block holds the bus idle for a number of cycles. That number is the largest of several per-condition needs and a programmed minimum for the area; the needs are not added together. The conditions are: the area honours the external WAIT pin, the access was a read, the area's hold-width field, and the memory kind. While idle cycles are counting, no new request is accepted. When no request is pending, nothing is issued.

Top module: `ext_idle_sched`

## Requirements
- R1: After reset `req_ready` is 1, `cyc_valid` is 0 and `idle_slot` is 0.
- R2: For a plain or PCMCIA area whose `cfg_wait_ignore` bit is 0, one idle cycle follows the final cycle of any access.
- R3: When `cfg_wait_ignore` is 1, the hold field is non-zero or the access is a write, and the minimum is 0, a plain-area access is followed by no idle cycle.
- R4: A read from a plain area whose 2-bit hold field is 00 is followed by one idle cycle.
- R5: A read from a plain area whose hold field is not 00 gets no read idle cycle.
- R6: A read from an SDRAM area (`req_mtype`=1) or a PCMCIA area (`req_mtype`=2) is always followed by one idle cycle. A write to an SDRAM area gets no WAIT-check idle cycle, even when `cfg_wait_ignore` is 0.
- R7: Access sizes are encoded as `req_size` 0=8, 1=16 and 2=32 bits. An access wider than the bus is issued as back-to-back sub-cycles, with the address rising by the bus width in bytes. `cyc_pos` is 00 for an undivided cycle, 01 for the first sub-cycle, 10 for a middle one and 11 for the last. `cyc_last` is 1 only on the final cycle. No idle cycle is inserted between sub-cycles, and the read idle cycle only follows the last one.
- R8: The idle count is the maximum of the condition needs (each 0 or 1) and the area's `cfg_min_idle` field. It is never their sum.
- R9: `req_ready` is 0 while an access is in progress or idle cycles remain. While `cyc_valid` is 1 and `cyc_ready` is 0, all cycle outputs hold steady.
- R10: With no request pending, `cyc_valid` stays 0 and `idle_slot` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_addr | input | ADDR_W | Byte start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0=8, 1=16, 2=32 bit (3 treated as 32) |
| req_mtype | input | 2 | 0 plain, 1 SDRAM, 2 PCMCIA |
| req_area | input | AREA_W | Chip-select area |
| cfg_wait_ignore | input | AREAS | Per area: 1 = WAIT pin ignored |
| cfg_hold | input | 2*AREAS | Per area 2-bit hold-width field |
| cfg_min_idle | input | MIN_W*AREAS | Per area programmed minimum idle count |
| cyc_valid | output | 1 | Bus cycle offered |
| cyc_ready | input | 1 | Sequencer takes the cycle |
| cyc_addr | output | ADDR_W | Address of this cycle |
| cyc_write | output | 1 | Direction of this cycle |
| cyc_area | output | AREA_W | Area of this cycle |
| cyc_pos | output | 2 | 00 single, 01 first, 10 middle, 11 last |
| cyc_last | output | 1 | Final cycle of the access |
| idle_slot | output | 1 | High in each inserted idle cycle |

## Verification
Single-cycle accesses are run through four areas configured to isolate one condition each: WAIT honoured, WAIT ignored, hold field set, and a large minimum. Reads against writes, and plain against SDRAM and PCMCIA kinds, show whether each condition fires only where it should. Divided 16- and 32-bit accesses on the 8-bit bus tell apart the position tags and address steps, and show whether the read idle cycle leaks between sub-cycles. An area where two conditions and a minimum of three apply at once shows maximum-taking apart from summing. A stalled sequencer and a quiet interval check that outputs hold and that nothing is issued spontaneously.

// File: rtl/ext_idle_sched.sv
module ext_idle_sched #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 32,
  parameter int AREAS  = 4,
  parameter int MIN_W  = 4,
  localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_write,
  input  logic [1:0]             req_size,
  input  logic [1:0]             req_mtype,
  input  logic [AREA_W-1:0]      req_area,
  input  logic [AREAS-1:0]       cfg_wait_ignore,
  input  logic [2*AREAS-1:0]     cfg_hold,
  input  logic [MIN_W*AREAS-1:0] cfg_min_idle,
  output logic                   cyc_valid,
  input  logic                   cyc_ready,
  output logic [ADDR_W-1:0]      cyc_addr,
  output logic                   cyc_write,
  output logic [AREA_W-1:0]      cyc_area,
  output logic [1:0]             cyc_pos,
  output logic                   cyc_last,
  output logic                   idle_slot
);
  localparam int BUS_BYTES = BUS_W / 8;
  localparam int BUS_LG    = $clog2(BUS_BYTES);
  localparam logic [1:0] MT_PLAIN = 2'd0;
  localparam logic [1:0] MT_SDRAM = 2'd1;

  logic              busy, first_q, div_q, write_q;
  logic [1:0]        left_q, mtype_q, size_eff, split_lg;
  logic [ADDR_W-1:0] addr_q;
  logic [AREA_W-1:0] area_q;
  logic [MIN_W-1:0]  idle_cnt, idle_next, min_q;
  logic              wait_need, read_need, take, fire;

  assign size_eff = (req_size == 2'd3) ? 2'd2 : req_size;
  assign split_lg = (int'(size_eff) > BUS_LG) ? 2'(int'(size_eff) - BUS_LG) : 2'd0;

  assign req_ready = !busy && (idle_cnt == '0);
  assign take      = req_valid && req_ready;
  assign fire      = cyc_valid && cyc_ready;

  assign cyc_valid = busy;
  assign cyc_addr  = addr_q;
  assign cyc_write = write_q;
  assign cyc_area  = area_q;
  assign cyc_last  = (left_q == 2'd0);
  assign cyc_pos   = !div_q ? 2'b00 : first_q ? 2'b01 : cyc_last ? 2'b11 : 2'b10;
  assign idle_slot = (idle_cnt != '0);

  assign wait_need = (mtype_q != MT_SDRAM) && !cfg_wait_ignore[area_q];
  assign read_need = !write_q &&
                     ((mtype_q != MT_PLAIN) || (cfg_hold[2*area_q +: 2] == 2'b00));
  assign min_q     = cfg_min_idle[MIN_W*area_q +: MIN_W];
  assign idle_next = (min_q > MIN_W'(wait_need || read_need)) ? min_q
                                                               : MIN_W'(wait_need || read_need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      first_q  <= 1'b0;
      div_q    <= 1'b0;
      write_q  <= 1'b0;
      left_q   <= 2'd0;
      mtype_q  <= 2'd0;
      addr_q   <= '0;
      area_q   <= '0;
      idle_cnt <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      first_q <= 1'b1;
      div_q   <= (split_lg != 2'd0);
      write_q <= req_write;
      left_q  <= 2'((3'd1 << split_lg) - 3'd1);
      mtype_q <= req_mtype;
      addr_q  <= req_addr;
      area_q  <= req_area;
    end else if (fire) begin
      first_q <= 1'b0;
      if (cyc_last) begin
        busy     <= 1'b0;
        idle_cnt <= idle_next;
      end else begin
        left_q <= left_q - 2'd1;
        addr_q <= addr_q + ADDR_W'(BUS_BYTES);
      end
    end else if (idle_cnt != '0) begin
      idle_cnt <= idle_cnt - 1'b1;
    end
  end

  a_r9_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || idle_slot) |-> !req_ready);
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_pos)
                                   && $stable(cyc_last)));
  a_r7_no_gap_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cyc_last) |=> (cyc_valid && !idle_slot));
  a_r6_ext_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cyc_last && !cyc_write && mtype_q != MT_PLAIN) |=> idle_slot);
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_slot && !busy) |=> (idle_cnt == $past(idle_cnt) - 1'b1));
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> !cyc_valid);
endmodule

// File: tb/tb_ext_idle_sched.sv
`timescale 1ns/1ps
module tb_ext_idle_sched;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_size = 0, req_mtype = 0;
  logic [1:0]  req_area = 0;
  logic [3:0]  cfg_wait_ignore;
  logic [7:0]  cfg_hold;
  logic [15:0] cfg_min_idle;
  logic        cyc_valid, cyc_ready = 1, cyc_write, cyc_last, idle_slot;
  logic [31:0] cyc_addr;
  logic [1:0]  cyc_area, cyc_pos;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  ext_idle_sched dut (.*);

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic acc(int area, int mt, bit wr, int sz, int addr, int exp_idle, string r);
    int n, i, idles;
    bit mid_gap;
    n = 1 << sz;
    @(negedge clk);
    req_area = 2'(area); req_mtype = 2'(mt); req_write = wr;
    req_size = 2'(sz); req_addr = addr; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    i = 0; mid_gap = 0;
    while (i < 8) begin
      if (!cyc_valid || idle_slot) mid_gap = 1;
      chk(cyc_addr == 32'(addr + i), {r, " addr"}, int'(cyc_addr), addr + i);
      chk(cyc_pos == ((n == 1) ? 2'd0 : (i == 0) ? 2'd1 : (i == n-1) ? 2'd3 : 2'd2),
          {r, " pos R7"}, int'(cyc_pos), -1);
      chk(cyc_last == (i == n-1), {r, " last R7"}, int'(cyc_last), int'(i == n-1));
      i++;
      if (cyc_last) break;
      @(negedge clk);
    end
    chk(i == n, {r, " subcycles R7"}, i, n);
    chk(!mid_gap, {r, " no gap R7"}, int'(mid_gap), 0);
    @(negedge clk);
    idles = 0;
    while (idle_slot && idles < 20) begin
      chk(!req_ready, {r, " ready low R9"}, int'(req_ready), 0);
      idles++;
      @(negedge clk);
    end
    chk(idles == exp_idle, {r, " idle count"}, idles, exp_idle);
    chk(req_ready, {r, " ready after idle"}, int'(req_ready), 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1 && cyc_valid == 0 && idle_slot == 0, "R1 reset",
        int'({req_ready, cyc_valid, idle_slot}), 4);
  endtask

  task automatic t_quiet();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!cyc_valid && !idle_slot, "R10 quiet", int'({cyc_valid, idle_slot}), 0);
    end
  endtask

  task automatic t_stall();
    @(negedge clk);
    cyc_ready = 0;
    req_area = 1; req_mtype = 0; req_write = 1; req_size = 2; req_addr = 32'h40; req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(cyc_valid && cyc_addr == 32'h40 && cyc_pos == 2'd1 && !req_ready,
          "R9 stall hold", int'(cyc_addr), 32'h40);
    end
    cyc_ready = 1;
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk(!cyc_valid && req_ready, "R9 stall drains", int'(cyc_valid), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg_wait_ignore = 4'b0110;
    cfg_hold        = {2'b00, 2'b01, 2'b00, 2'b00};
    cfg_min_idle    = {4'd3, 4'd0, 4'd0, 4'd0};
    #12 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_quiet();
    acc(0, 0, 1, 0, 'h10, 1, "R2 wait honoured write");
    acc(0, 2, 1, 0, 'h11, 1, "R2 pcmcia write wait");
    acc(1, 0, 1, 0, 'h12, 0, "R3 wait ignored write");
    acc(1, 0, 0, 0, 'h13, 1, "R4 read hold00");
    acc(2, 0, 0, 0, 'h14, 0, "R5 read hold01");
    acc(2, 1, 0, 0, 'h15, 1, "R6 sdram read");
    acc(2, 2, 0, 0, 'h16, 1, "R6 pcmcia read");
    acc(0, 1, 1, 0, 'h17, 0, "R6 sdram write no wait idle");
    acc(1, 0, 1, 2, 'h100, 0, "R7 32b write split");
    acc(2, 0, 0, 1, 'h200, 0, "R7 16b read split");
    acc(1, 0, 0, 2, 'h300, 1, "R7 32b read idle after last");
    acc(3, 0, 0, 0, 'h20, 3, "R8 max with min3");
    acc(0, 0, 0, 0, 'h21, 1, "R8 two needs not summed");
    t_stall();
    t_quiet();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule